// File: doc/BRIEF.md
# Software Write-Protect Command Decoder

This block sits between the captured host write path of a byte-wide flash device and its page-load write controller. Every captured write (address and data) passes through a command matcher. The matcher recognises short and long command sequences. All of them start with the same two-write key prefix: a key byte at the first command address, then a second key byte at the second command address. A third write at the first command address carries an operation byte. That byte either completes a three-write command or extends the sequence to six writes.

A protection flag decides whether ordinary data writes reach the page-load controller. When the flag is set, a data load passes only after the three-write arm command. Forwarding then stays open for the whole page-load cycle, which ends when the controller drops its busy indication. The flag models a non-volatile bit: the normal reset leaves it alone, and only a dedicated preset input can load it. Six-write sequences clear the flag, start a self-timed chip erase, or enter identification mode. In identification mode, reads at addresses 0 and 1 return fixed manufacturer and device codes. A three-write sequence leaves identification mode.

Top module: `swp_cmd_decoder`

## Requirements
- R1: `prot_on` changes only through `nv_load` (which loads `nv_value`) or through a protection command; asserting `rst` alone leaves it unchanged.
- R2: While `prot_on` is 1 and no load is armed, a write that does not belong to a command sequence is not forwarded.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h set `prot_on` and arm a load. Each later write is then forwarded one cycle after capture, with its address and data unchanged.
- R4: An armed load ends on the falling edge of `page_busy`. After that, writes made while protected are no longer forwarded.
- R5: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear `prot_on` in the cycle after the last write.
- R6: While unprotected, a write that is neither part of a sequence nor armed is forwarded one cycle later. A write that breaks a sequence returns the matcher to idle. That write is forwarded only when unprotected, and writes consumed by a sequence are never forwarded.
- R7: The six-write sequence ending in 10h@5555h pulses `erase_start` for one cycle and holds `erase_busy` high for exactly ERASE_CYC cycles, starting in the same cycle.
- R8: While `erase_busy` is high, writes are neither forwarded nor decoded as commands.
- R9: The six-write sequence ending in 60h@5555h sets `id_mode`. With `id_mode` set, `rd_data` is DAh at read address 0, C8h at address 1, and `arr_rdata` elsewhere. Without `id_mode`, `rd_data` always equals `arr_rdata`.
- R10: The writes AAh@5555h, 55h@2AAAh, F0h@5555h clear `id_mode`.
- R11: `rst` clears `id_mode`, the armed load, the matcher state, the erase timer and `fwd_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the protection flag) |
| nv_load | input | 1 | Presets the protection flag from `nv_value` |
| nv_value | input | 1 | Value loaded into the protection flag |
| wr_vld | input | 1 | A captured host write is present this cycle |
| wr_addr | input | 16 | Address of the captured write |
| wr_data | input | 8 | Data of the captured write |
| page_busy | input | 1 | High while the page-load controller is loading or programming a page |
| fwd_vld | output | 1 | Forwarded data load to the page-load controller |
| fwd_addr | output | 16 | Address of the forwarded load |
| fwd_data | output | 8 | Data of the forwarded load |
| prot_on | output | 1 | Protection flag |
| erase_start | output | 1 | One-cycle pulse that starts a chip erase |
| erase_busy | output | 1 | High while the chip erase runs |
| id_mode | output | 1 | Identification mode is active |
| rd_addr | input | 16 | Host read address |
| arr_rdata | input | 8 | Read data from the array |
| rd_data | output | 8 | Read data returned to the host |

## Verification
The bench targets sequences that are broken partway. A decoder that does not drop back to idle on the breaking write would later accept a stray 55h/A0h pair and arm a load, or it would pass the breaking write through while protected. The bench also checks that the armed window closes on the falling edge of `page_busy`. A decoder that never closes the window leaks the next unprotected write into the array. Other cases covered: command bytes sent while erase is busy, which a faulty decoder would remember and complete afterwards; a reset that wrongly clears protection; and the exact erase length and read-code addresses, where off-by-one faults show up.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_X0   = 3'd3,
        SQ_X1   = 3'd4,
        SQ_X2   = 3'd5
    } seq_e;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_PROT    = 3'd1,
        CMD_UNPROT  = 3'd2,
        CMD_ERASE   = 3'd3,
        CMD_ID_IN   = 3'd4,
        CMD_ID_OUT  = 3'd5
    } cmd_e;

    typedef struct packed {
        seq_e nxt;
        logic used;
        cmd_e cmd;
    } step_t;

    function automatic step_t mk_step(input seq_e nxt, input logic used, input cmd_e cmd);
        step_t s;
        s.nxt  = nxt;
        s.used = used;
        s.cmd  = cmd;
        return s;
    endfunction

endpackage

// File: rtl/swp_seq_match.sv
module swp_seq_match
    import swp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] ADDR_A    = 16'h5555,
    parameter logic [AW-1:0] ADDR_B    = 16'h2AAA,
    parameter logic [DW-1:0] KEY_A     = 8'hAA,
    parameter logic [DW-1:0] KEY_B     = 8'h55,
    parameter logic [DW-1:0] OP_PROT   = 8'hA0,
    parameter logic [DW-1:0] OP_EXT    = 8'h80,
    parameter logic [DW-1:0] OP_ID_OUT = 8'hF0,
    parameter logic [DW-1:0] OP_UNPROT = 8'h20,
    parameter logic [DW-1:0] OP_ERASE  = 8'h10,
    parameter logic [DW-1:0] OP_ID_IN  = 8'h60
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          consumed,
    output cmd_e          cmd
);

    seq_e  st_q;
    step_t step;
    logic  hit_a, hit_b, at_a;

    assign at_a  = (addr == ADDR_A);
    assign hit_a = at_a && (data == KEY_A);
    assign hit_b = (addr == ADDR_B) && (data == KEY_B);

    always_comb begin
        step = mk_step(st_q, 1'b0, CMD_NONE);
        if (en) begin
            step = mk_step(SQ_IDLE, 1'b0, CMD_NONE);
            unique case (st_q)
                SQ_IDLE: begin
                    if (hit_a) step = mk_step(SQ_K1, 1'b1, CMD_NONE);
                end
                SQ_K1: begin
                    if (hit_b)      step = mk_step(SQ_K2, 1'b1, CMD_NONE);
                    else if (hit_a) step = mk_step(SQ_K1, 1'b1, CMD_NONE);
                end
                SQ_K2: begin
                    if (at_a && data == OP_PROT)        step = mk_step(SQ_IDLE, 1'b1, CMD_PROT);
                    else if (at_a && data == OP_ID_OUT) step = mk_step(SQ_IDLE, 1'b1, CMD_ID_OUT);
                    else if (at_a && data == OP_EXT)    step = mk_step(SQ_X0, 1'b1, CMD_NONE);
                    else if (hit_a)                     step = mk_step(SQ_K1, 1'b1, CMD_NONE);
                end
                SQ_X0: begin
                    if (hit_a) step = mk_step(SQ_X1, 1'b1, CMD_NONE);
                end
                SQ_X1: begin
                    if (hit_b)      step = mk_step(SQ_X2, 1'b1, CMD_NONE);
                    else if (hit_a) step = mk_step(SQ_K1, 1'b1, CMD_NONE);
                end
                SQ_X2: begin
                    if (at_a && data == OP_UNPROT)     step = mk_step(SQ_IDLE, 1'b1, CMD_UNPROT);
                    else if (at_a && data == OP_ERASE) step = mk_step(SQ_IDLE, 1'b1, CMD_ERASE);
                    else if (at_a && data == OP_ID_IN) step = mk_step(SQ_IDLE, 1'b1, CMD_ID_IN);
                    else if (hit_a)                    step = mk_step(SQ_K1, 1'b1, CMD_NONE);
                end
                default: step = mk_step(SQ_IDLE, 1'b0, CMD_NONE);
            endcase
        end
    end

    assign consumed = step.used;
    assign cmd      = step.cmd;

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= step.nxt;
    end

    // R6
    break_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !consumed) |=> (st_q == SQ_IDLE));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (st_q == SQ_IDLE));

endmodule

// File: rtl/swp_prot_state.sv
module swp_prot_state (
    input  logic clk,
    input  logic rst,
    input  logic nv_load,
    input  logic nv_value,
    input  logic set_prot,
    input  logic clr_prot,
    input  logic page_busy,
    output logic prot_on,
    output logic armed
);

    logic prot_q;
    logic armed_q;
    logic pb_q;

    // Persistent flag: no reset term, only the preset input and commands.
    always_ff @(posedge clk) begin
        if (nv_load)       prot_q <= nv_value;
        else if (set_prot) prot_q <= 1'b1;
        else if (clr_prot) prot_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            pb_q    <= 1'b0;
        end else begin
            pb_q <= page_busy;
            if (set_prot)                armed_q <= 1'b1;
            else if (pb_q && !page_busy) armed_q <= 1'b0;
        end
    end

    assign prot_on = prot_q;
    assign armed   = armed_q;

    // R1
    prot_keep_chk: assert property (@(posedge clk)
        (rst && !nv_load) |=> (prot_q == $past(prot_q)));

    // R4
    arm_close_chk: assert property (@(posedge clk) disable iff (rst)
        (pb_q && !page_busy && !set_prot) |=> !armed_q);

endmodule

// File: rtl/swp_erase_timer.sv
module swp_erase_timer #(
    parameter int CYC = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic start_pulse,
    output logic busy
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= start && !busy_q;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(CYC - 1);
            end else if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign start_pulse = start_q;
    assign busy        = busy_q;

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> start_q);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

endmodule

// File: rtl/swp_id_read.sv
module swp_id_read #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [DW-1:0] MFR_CODE = 8'hDA,
    parameter logic [DW-1:0] DEV_CODE = 8'hC8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enter,
    input  logic          leave,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic          id_mode,
    output logic [DW-1:0] rd_data
);

    logic id_q;

    always_ff @(posedge clk) begin
        if (rst)        id_q <= 1'b0;
        else if (enter) id_q <= 1'b1;
        else if (leave) id_q <= 1'b0;
    end

    always_comb begin
        rd_data = arr_rdata;
        if (id_q && rd_addr == AW'(0)) rd_data = MFR_CODE;
        else if (id_q && rd_addr == AW'(1)) rd_data = DEV_CODE;
    end

    assign id_mode = id_q;

    // R9
    mfr_code_chk: assert property (@(posedge clk) disable iff (rst)
        (id_q && rd_addr == AW'(0)) |-> (rd_data == MFR_CODE));

    // R10
    id_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (leave && !enter) |=> !id_q);

endmodule

// File: rtl/swp_cmd_decoder.sv
module swp_cmd_decoder
    import swp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int ERASE_CYC = 12_500_000,
    parameter logic [AW-1:0] ADDR_A    = 16'h5555,
    parameter logic [AW-1:0] ADDR_B    = 16'h2AAA,
    parameter logic [DW-1:0] KEY_A     = 8'hAA,
    parameter logic [DW-1:0] KEY_B     = 8'h55,
    parameter logic [DW-1:0] OP_PROT   = 8'hA0,
    parameter logic [DW-1:0] OP_EXT    = 8'h80,
    parameter logic [DW-1:0] OP_ID_OUT = 8'hF0,
    parameter logic [DW-1:0] OP_UNPROT = 8'h20,
    parameter logic [DW-1:0] OP_ERASE  = 8'h10,
    parameter logic [DW-1:0] OP_ID_IN  = 8'h60,
    parameter logic [DW-1:0] MFR_CODE  = 8'hDA,
    parameter logic [DW-1:0] DEV_CODE  = 8'hC8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nv_load,
    input  logic          nv_value,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          page_busy,
    output logic          fwd_vld,
    output logic [AW-1:0] fwd_addr,
    output logic [DW-1:0] fwd_data,
    output logic          prot_on,
    output logic          erase_start,
    output logic          erase_busy,
    output logic          id_mode,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data
);

    logic armed;
    logic match_en;
    logic consumed;
    cmd_e cmd;
    logic fwd_next;

    assign match_en = wr_vld && !erase_busy && !armed;

    swp_seq_match #(
        .AW(AW), .DW(DW),
        .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
        .KEY_A(KEY_A), .KEY_B(KEY_B),
        .OP_PROT(OP_PROT), .OP_EXT(OP_EXT), .OP_ID_OUT(OP_ID_OUT),
        .OP_UNPROT(OP_UNPROT), .OP_ERASE(OP_ERASE), .OP_ID_IN(OP_ID_IN)
    ) u_match (
        .clk(clk), .rst(rst), .en(match_en),
        .addr(wr_addr), .data(wr_data),
        .consumed(consumed), .cmd(cmd)
    );

    swp_prot_state u_prot (
        .clk(clk), .rst(rst),
        .nv_load(nv_load), .nv_value(nv_value),
        .set_prot(cmd == CMD_PROT), .clr_prot(cmd == CMD_UNPROT),
        .page_busy(page_busy),
        .prot_on(prot_on), .armed(armed)
    );

    swp_erase_timer #(.CYC(ERASE_CYC)) u_erase (
        .clk(clk), .rst(rst),
        .start(cmd == CMD_ERASE),
        .start_pulse(erase_start), .busy(erase_busy)
    );

    swp_id_read #(
        .AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_id (
        .clk(clk), .rst(rst),
        .enter(cmd == CMD_ID_IN), .leave(cmd == CMD_ID_OUT),
        .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .id_mode(id_mode), .rd_data(rd_data)
    );

    assign fwd_next = wr_vld && !erase_busy && (armed || (!consumed && !prot_on));

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_vld  <= 1'b0;
            fwd_addr <= '0;
            fwd_data <= '0;
        end else begin
            fwd_vld <= fwd_next;
            if (fwd_next) begin
                fwd_addr <= wr_addr;
                fwd_data <= wr_data;
            end
        end
    end

    // R8
    erase_block_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |=> !fwd_vld);

    // R2
    prot_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && prot_on && !armed && !nv_load) |=> !fwd_vld);

    // R3
    arm_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && armed && !erase_busy) |=> (fwd_vld && fwd_addr == $past(wr_addr)
                                               && fwd_data == $past(wr_data)));

endmodule

// File: tb/swp_cmd_decoder_bench.sv
`timescale 1ns/1ps
module swp_cmd_decoder_bench;

    localparam int ECYC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nv_load = 1'b0, nv_value = 1'b0;
    logic        wr_vld = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_busy = 1'b0;
    logic        fwd_vld;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_data;
    logic        prot_on, erase_start, erase_busy, id_mode;
    logic [15:0] rd_addr = '0;
    logic [7:0]  arr_rdata = 8'h5A;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    swp_cmd_decoder #(.ERASE_CYC(ECYC)) u_swp_cmd_decoder (
        .clk(clk), .rst(rst), .nv_load(nv_load), .nv_value(nv_value),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_busy(page_busy),
        .fwd_vld(fwd_vld), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
        .prot_on(prot_on), .erase_start(erase_start), .erase_busy(erase_busy),
        .id_mode(id_mode), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one write per two cycles; expected loads go to the scoreboard.
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit pass);
        @(negedge clk);
        wr_vld = 1'b1; wr_addr = a; wr_data = d;
        if (pass) exp_q.push_back({a, d});
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic key3(input logic [7:0] op);
        wr(16'h5555, 8'hAA, 0);
        wr(16'h2AAA, 8'h55, 0);
        wr(16'h5555, op, 0);
    endtask

    task automatic key6(input logic [7:0] op);
        key3(8'h80);
        key3(op);
    endtask

    // Monitor: every forwarded load must match the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst && fwd_vld && !done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2/R6 unexpected load", {8'h0, fwd_addr, fwd_data}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({fwd_addr, fwd_data} == e, "R3/R6 load", {8'h0, fwd_addr, fwd_data}, {8'h0, e});
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        nv_load = 1'b1; nv_value = 1'b1;
        repeat (3) @(negedge clk);
        nv_load = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state, R1 preset
        chk(prot_on == 1'b1, "R1 preset", prot_on, 1);
        chk(fwd_vld == 1'b0 && id_mode == 1'b0 && erase_busy == 1'b0, "R11 reset outputs",
            {fwd_vld, id_mode, erase_busy}, 0);

        // R2 plain write while protected is dropped
        wr(16'h1234, 8'h77, 0);

        // R3 arm command then page load
        key3(8'hA0);
        chk(prot_on == 1'b1, "R3 protect stays", prot_on, 1);
        wr(16'h0100, 8'h11, 1);
        page_busy = 1'b1;
        wr(16'h017F, 8'h22, 1);
        @(negedge clk);
        page_busy = 1'b0;
        @(negedge clk);
        // R4 window closed
        wr(16'h0100, 8'h33, 0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R4 no leak after page end", exp_q.size(), 0);

        // R6 broken prefix, R2 the rest dropped
        wr(16'h5555, 8'hAA, 0);
        wr(16'h2AAA, 8'h12, 0);
        wr(16'h2AAA, 8'h55, 0);
        wr(16'h5555, 8'hA0, 0);
        wr(16'h0200, 8'h44, 0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 broken sequence does not arm", exp_q.size(), 0);

        // R5 disable
        key6(8'h20);
        chk(prot_on == 1'b0, "R5 disable", prot_on, 0);

        // R6 unprotected forwarding, sequence break forwarded
        wr(16'h0300, 8'h55, 1);
        wr(16'h5555, 8'hAA, 0);
        wr(16'h1000, 8'h99, 1);

        // R1 reset keeps the flag; preset changes it
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk(prot_on == 1'b0, "R1 reset keeps clear flag", prot_on, 0);
        nv_load = 1'b1; nv_value = 1'b1;
        @(negedge clk);
        chk(prot_on == 1'b1, "R1 preset set", prot_on, 1);
        @(negedge clk); rst = 1'b1;
        nv_load = 1'b0;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk(prot_on == 1'b1, "R1 reset keeps set flag", prot_on, 1);
        nv_load = 1'b1; nv_value = 1'b0;
        @(negedge clk);
        nv_load = 1'b0;

        // R9 identification reads
        rd_addr = 16'h0000; #1;
        chk(rd_data == 8'h5A, "R9 array read outside id mode", rd_data, 8'h5A);
        key6(8'h60);
        chk(id_mode == 1'b1, "R9 id entry", id_mode, 1);
        rd_addr = 16'h0000; #1;
        chk(rd_data == 8'hDA, "R9 mfr code", rd_data, 8'hDA);
        rd_addr = 16'h0001; #1;
        chk(rd_data == 8'hC8, "R9 dev code", rd_data, 8'hC8);
        rd_addr = 16'h0002; #1;
        chk(rd_data == 8'h5A, "R9 other address", rd_data, 8'h5A);
        // R10 leave
        key3(8'hF0);
        chk(id_mode == 1'b0, "R10 id exit", id_mode, 0);
        rd_addr = 16'h0000; #1;
        chk(rd_data == 8'h5A, "R10 array after exit", rd_data, 8'h5A);

        // R7 erase length
        key6(8'h10);
        chk(erase_start == 1'b1 && erase_busy == 1'b1, "R7 erase start", {erase_start, erase_busy}, 2'b11);
        @(negedge clk);
        chk(erase_start == 1'b0, "R7 single pulse", erase_start, 0);
        n = 1;
        while (erase_busy) begin n++; @(negedge clk); end
        chk(n == ECYC, "R7 busy length", n, ECYC);

        // R8 commands ignored while busy
        key6(8'h10);
        wr(16'h5555, 8'hAA, 0);
        wr(16'h2AAA, 8'h55, 0);
        while (erase_busy) @(negedge clk);
        wr(16'h5555, 8'hA0, 1);
        chk(prot_on == 1'b0, "R8 no command completed across erase", prot_on, 0);

        // R11 reset leaves id mode
        key6(8'h60);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(id_mode == 1'b0, "R11 reset clears id mode", id_mode, 0);

        // R3 arm command from unprotected state sets the flag
        key3(8'hA0);
        chk(prot_on == 1'b1, "R3 enable", prot_on, 1);
        wr(16'h0400, 8'h66, 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3/R6 all expected loads seen", exp_q.size(), 0);
        finish_run();
    end

endmodule